// File: doc/BRIEF.md
# Prioritized Eight-Input Interrupt Controller

This block gathers eight asynchronous interrupt request lines into one interrupt output for a processor. Each line is synchronized and captured in a pending register. A per-line mask screens it, and a fixed-priority resolver picks the winner, with line 0 the most urgent. A line whose priority is equal to or below the most urgent line already being serviced cannot raise the output. This gives nested servicing: only a more urgent line can interrupt a service routine.

The processor answers the interrupt output with a one-cycle acknowledge strobe. In that cycle the current winner is committed into the in-service register. The block then presents a vector equal to a programmable base plus the line number times a step of 4 or 8. The processor ends service with an end-of-service command. A small port sits on a chip select, read and write strobes and a single address bit. Through it the processor programs the mask, the trigger mode, the vector step and the base, and reads back the mask, the pending lines or the in-service lines.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each request line passes through two synchronizer flops. A change on a line appears in the pending register on the third rising clock edge after it is applied.
- R2: In level mode (config bit 0 = 0), a pending bit follows the synchronized line. In edge mode (config bit 0 = 1), a pending bit is set by a synchronized low-to-high transition and clears when the line falls or when that line wins an acknowledge. A line held high after acknowledge does not become pending again.
- R3: A write with address bit 1 loads the mask. Mask bit 1 disables its line and 0 enables it. A masked line never raises the interrupt output and never blocks a less urgent enabled line.
- R4: The interrupt output is high exactly when some enabled pending line has a lower index than every set in-service bit.
- R5: On acknowledge, the lowest-index line that can raise the output sets its in-service bit. In edge mode its pending bit also clears.
- R6: After acknowledge, the vector output equals base plus line times step, modulo 256. The step is 8 when config bit 1 = 1 and 4 otherwise. If no line can win, the vector uses line 7 and the in-service register is unchanged. The vector holds between acknowledges.
- R7: Command writes use address bit 0, with the opcode in data bits 7:6. Opcode 01 is end of service and clears the lowest-index set in-service bit; with none set it has no effect. Opcode 10 loads the config from data bits 1:0. Opcode 11 loads the base as data bits 5:0 times 4. Opcode 00 loads the read select from data bit 0.
- R8: While chip select and read are both low, the read data shows the mask when address bit = 1. When address bit = 0 it shows the pending register (select 0) or the in-service register (select 1). Otherwise the read data is 0.
- R9: After reset: mask all ones, pending and in-service cleared, level mode, step 4, base 0, read select 0, vector 0, interrupt output low.
- R10: A write strobe while chip select is high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 8 | Asynchronous request lines, index 0 most urgent |
| cs_n | input | 1 | Register port chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, one cycle per write |
| addr_i | input | 1 | Register address: 1 = mask, 0 = command/status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not reading |
| ack_i | input | 1 | One-cycle acknowledge strobe from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledged line |

## Verification
Corrupt pending, mask or in-service state shows up as a wrong interrupt level on `int_o` in the same cycle the state goes wrong, because the output is decoded combinationally from those registers. A wrong priority choice shows up as a wrong `vec_o` one edge after the acknowledge. It also leaves a wrong set of in-service bits, which later gives a wrong interrupt level after end of service and a wrong status readback on `rdata_o`. Synchronizer and edge-capture faults shift the first pending cycle away from the third edge, so a comparison on every clock sees them within a few cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // opcode carried in the two top bits of a command write
  typedef enum logic [1:0] {
    CMD_RSEL = 2'b00,
    CMD_EOI  = 2'b01,
    CMD_CFG  = 2'b10,
    CMD_BASE = 2'b11
  } cmd_op_e;

  typedef struct packed {
    logic edge_mode;  // 1: transition triggered, 0: level triggered
    logic wide_step;  // 1: vector step 8, 0: vector step 4
  } cfg_t;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  localparam int CHAIN_W = STAGES * N;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[CHAIN_W-N-1:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[CHAIN_W-1 -: N];

  // first flop captures the raw line on every edge
  assert_first_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> chain_q[N-1:0] == $past(d_i));

endmodule

// File: rtl/irqc_req_reg.sv
module irqc_req_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic         edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] rise;

  assign rise = lvl_i & ~prev_q;

  always_comb begin
    if (edge_mode_i) pend_d = (pend_q | rise) & lvl_i & ~clr_i;
    else             pend_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((pend_q & $past(clr_i)) == '0));

  assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode_i |=> pend_q == $past(lvl_i));

  assert_edge_needs_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i |=> ((pend_q & ~$past(lvl_i)) == '0));

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     isr_i,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [N-1:0]     isr_top_o
);

  logic [N-1:0] elig;
  logic [N-1:0] allow;
  logic [N-1:0] cand;
  logic         blocked;

  // a line may win only if no in-service bit sits at or above its priority
  always_comb begin
    elig    = pend_i & ~mask_i;
    blocked = 1'b0;
    allow   = '0;
    for (int i = 0; i < N; i++) begin
      blocked  = blocked | isr_i[i];
      allow[i] = ~blocked;
    end
    cand = elig & allow;
  end

  always_comb begin
    win_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) win_idx_o = IDX_W'(i);
    end
  end

  assign win_valid_o = |cand;
  assign isr_top_o   = isr_i & (~isr_i + 1'b1);

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  output logic [N-1:0]  mask_o,
  output cfg_t          cfg_o,
  output logic [DW-1:0] base_o,
  output logic          eoi_o,
  output logic [DW-1:0] rdata_o
);

  localparam int BASE_SHIFT = 2;
  localparam int BASE_SRC_W = DW - BASE_SHIFT;

  logic    wr_en;
  logic    rd_en;
  logic    cmd_we;
  cmd_op_e op;

  logic    mask_we, cfg_we, base_we, rsel_we;

  logic [N-1:0]  mask_q, mask_d;
  cfg_t          cfg_q, cfg_d;
  logic [DW-1:0] base_q, base_d;
  logic          rsel_q, rsel_d;

  assign wr_en  = ~cs_n_i & ~wr_n_i;
  assign rd_en  = ~cs_n_i & ~rd_n_i;
  assign op     = cmd_op_e'(wdata_i[DW-1 -: 2]);
  assign cmd_we = wr_en & ~addr_i;

  assign mask_we = wr_en & addr_i;
  assign cfg_we  = cmd_we & (op == CMD_CFG);
  assign base_we = cmd_we & (op == CMD_BASE);
  assign rsel_we = cmd_we & (op == CMD_RSEL);
  assign eoi_o   = cmd_we & (op == CMD_EOI);

  always_comb begin
    mask_d           = wdata_i[N-1:0];
    cfg_d.edge_mode  = wdata_i[0];
    cfg_d.wide_step  = wdata_i[1];
    base_d           = {wdata_i[BASE_SRC_W-1:0], {BASE_SHIFT{1'b0}}};
    rsel_d           = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      cfg_q  <= '0;
      base_q <= '0;
      rsel_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (cfg_we)  cfg_q  <= cfg_d;
      if (base_we) base_q <= base_d;
      if (rsel_we) rsel_q <= rsel_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (addr_i)      rdata_o[N-1:0] = mask_q;
      else if (rsel_q) rdata_o[N-1:0] = isr_i;
      else             rdata_o[N-1:0] = pend_i;
    end
  end

  assign mask_o = mask_q;
  assign cfg_o  = cfg_q;
  assign base_o = base_q;

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !wr_n_i && addr_i) |=> mask_q == $past(wdata_i[N-1:0]));

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> ($stable(mask_q) && $stable(base_q) && $stable(rsel_q) && cfg_q == $past(cfg_q)));

  assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |-> rdata_o == '0);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_i,
  output logic              int_o,
  output logic [DATA_W-1:0] vec_o
);

  localparam int IDX_W     = $clog2(N_LINES);
  localparam int SPUR_IDX  = N_LINES - 1;
  localparam int NARROW_SH = 2;
  localparam int WIDE_SH   = 3;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [N_LINES-1:0] lvl;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] mask;
  logic [N_LINES-1:0] isr_q, isr_d;
  logic [N_LINES-1:0] isr_top;
  logic [N_LINES-1:0] isr_set;
  logic [N_LINES-1:0] isr_clr;
  logic [N_LINES-1:0] pend_clr;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  cfg_t               cfg;
  logic [DATA_W-1:0]  base;
  logic               eoi;
  logic [DATA_W-1:0]  vec_q, vec_d;
  logic [IDX_W-1:0]   vec_idx;
  logic               vec_en;

  irqc_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (irq_i),
    .q_o   (lvl)
  );

  irqc_req_reg #(.N(N_LINES)) u_req (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lvl_i       (lvl),
    .edge_mode_i (cfg.edge_mode),
    .clr_i       (pend_clr),
    .pend_o      (pend)
  );

  irqc_resolver #(.N(N_LINES), .IDX_W(IDX_W)) u_res (
    .pend_i      (pend),
    .mask_i      (mask),
    .isr_i       (isr_q),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .isr_top_o   (isr_top)
  );

  irqc_regif #(.N(N_LINES), .DW(DATA_W)) u_regif (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cs_n_i  (cs_n),
    .rd_n_i  (rd_n),
    .wr_n_i  (wr_n),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend),
    .isr_i   (isr_q),
    .mask_o  (mask),
    .cfg_o   (cfg),
    .base_o  (base),
    .eoi_o   (eoi),
    .rdata_o (rdata_o)
  );

  // in-service update: acknowledge sets the winner, end of service drops the top bit
  always_comb begin
    isr_set  = '0;
    pend_clr = '0;
    if (ack_i && win_valid) begin
      isr_set[win_idx] = 1'b1;
      if (cfg.edge_mode) pend_clr[win_idx] = 1'b1;
    end
    isr_clr = eoi ? isr_top : '0;
    isr_d   = (isr_q | isr_set) & ~isr_clr;
  end

  // vector update
  always_comb begin
    vec_en  = ack_i;
    vec_idx = win_valid ? win_idx : IDX_W'(SPUR_IDX);
    if (cfg.wide_step) vec_d = base + (DATA_W'(vec_idx) << WIDE_SH);
    else               vec_d = base + (DATA_W'(vec_idx) << NARROW_SH);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign int_o = win_valid;
  assign vec_o = vec_q;

  assert_int_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    int_o |-> |(pend & ~mask));

  assert_ack_adds_one_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_i && int_o && !eoi) |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  assert_spurious_keeps_isr_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_i && !int_o && !eoi) |=> isr_q == $past(isr_q));

  assert_vec_holds_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ack_i |=> $stable(vec_o));

  assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eoi && !ack_i && (|isr_q)) |=> $countones(isr_q) == $past($countones(isr_q)) - 1);

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == '1) |-> !int_o);

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] irq;
  logic       cs_n, rd_n, wr_n, addr, ack;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       int_o;
  logic [7:0] vec;

  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string tag     = "R9";

  irq_prio_ctrl dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .ack_i   (ack),
    .int_o   (int_o),
    .vec_o   (vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // ---------------- behavioural reference ----------------
  logic [7:0] m_h1, m_h2, m_hp, m_pend, m_mask, m_isr, m_base, m_vec;
  bit         m_edge, m_wide, m_rsel;

  function automatic int m_winner();
    int lim;
    lim = 8;
    for (int i = 7; i >= 0; i--) if (m_isr[i]) lim = i;
    for (int i = 0; i < 8; i++) if (i < lim && m_pend[i] && !m_mask[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] m_rdata();
    if (cs_n || rd_n) return 8'h00;
    if (addr)   return m_mask;
    if (m_rsel) return m_isr;
    return m_pend;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int w, step;
    logic [7:0] n_isr, clr, n_pend;
    bit wr;
    if (!rst_n) begin
      m_h1 = 0; m_h2 = 0; m_hp = 0; m_pend = 0; m_mask = 8'hFF; m_isr = 0;
      m_base = 0; m_vec = 0; m_edge = 0; m_wide = 0; m_rsel = 0;
    end else begin
      w     = m_winner();
      step  = m_wide ? 8 : 4;
      n_isr = m_isr;
      clr   = 0;
      wr    = !cs_n && !wr_n;
      if (ack) begin
        if (w >= 0) begin
          n_isr[w] = 1'b1;
          if (m_edge) clr[w] = 1'b1;
          m_vec = 8'(m_base + w * step);
        end else begin
          m_vec = 8'(m_base + 7 * step);
        end
      end
      if (wr && !addr && wdata[7:6] == 2'b01) begin
        for (int i = 0; i < 8; i++) if (m_isr[i]) begin n_isr[i] = 1'b0; break; end
      end
      if (m_edge) n_pend = (m_pend | (m_h2 & ~m_hp)) & m_h2 & ~clr;
      else        n_pend = m_h2;
      if (wr && addr) m_mask = wdata;
      if (wr && !addr) begin
        case (wdata[7:6])
          2'b00: m_rsel = wdata[0];
          2'b10: begin m_edge = wdata[0]; m_wide = wdata[1]; end
          2'b11: m_base = {wdata[5:0], 2'b00};
          default: ;
        endcase
      end
      m_hp   = m_h2;
      m_h2   = m_h1;
      m_h1   = irq;
      m_pend = n_pend;
      m_isr  = n_isr;
    end
  end

  // ---------------- comparison on every clock ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (int_o !== (m_winner() >= 0)) begin
        fails++;
        $display("FAIL %s int_o actual %0b expected %0b", tag, int_o, m_winner() >= 0);
      end
      if (vec !== m_vec) begin
        fails++;
        $display("FAIL %s vec_o actual %02h expected %02h", tag, vec, m_vec);
      end
      if (rdata !== m_rdata()) begin
        fails++;
        $display("FAIL %s rdata_o actual %02h expected %02h", tag, rdata, m_rdata());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual %0d cycles expected under 60000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1; ack = 0; addr = 0; wdata = 0;
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    tick();
    idle();
  endtask

  task automatic rd_reg(input logic a);
    cs_n = 0; rd_n = 0; addr = a;
    tick();
    idle();
  endtask

  task automatic ack_pulse();
    ack = 1;
    tick();
    ack = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) tick();
  endtask

  initial begin
    idle();
    irq   = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    wait_n(4);

    tag = "R9"; // reset values via readback
    rd_reg(1); rd_reg(0); wr_reg(0, 8'h01); rd_reg(0); wr_reg(0, 8'h00);

    tag = "R3"; // enable all lines, read mask back
    wr_reg(1, 8'h00); rd_reg(1);

    tag = "R1"; // level request timing, sampled every cycle
    irq = 8'h08;
    rd_reg(0); rd_reg(0); rd_reg(0); rd_reg(0);

    tag = "R5"; // acknowledge in level mode, step 4 vector 12
    ack_pulse(); wait_n(1);
    wr_reg(0, 8'h01); rd_reg(0);

    tag = "R7"; // end of service re-raises since the level stays high
    wr_reg(0, 8'h40); wait_n(2);
    irq = 0; wait_n(4);
    wr_reg(0, 8'h40); wait_n(1); // empty in-service: no effect

    tag = "R6"; // edge mode, step 8, base 0x40
    wr_reg(0, 8'h83);
    wr_reg(0, 8'hD0);
    irq = 8'h24; wait_n(4);
    ack_pulse(); wait_n(1);

    tag = "R4"; // line 5 pending but below in-service line 2
    wr_reg(0, 8'h00); rd_reg(0); wait_n(2);
    irq = 8'h25; wait_n(4);
    ack_pulse(); wait_n(1);
    wr_reg(0, 8'h01); rd_reg(0);

    tag = "R7";
    wr_reg(0, 8'h40); wait_n(1);
    wr_reg(0, 8'h40); wait_n(1);
    ack_pulse(); wait_n(1);
    wr_reg(0, 8'h40); wait_n(1);

    tag = "R2"; // held-high lines do not come back in edge mode
    wait_n(3);
    wr_reg(0, 8'h00); rd_reg(0);
    irq = 8'h00; wait_n(4);
    irq = 8'h10; wait_n(4);
    irq = 8'h00; wait_n(4); // dropped before acknowledge
    rd_reg(0);

    tag = "R3"; // mask line 1, lower line 6 still served
    wr_reg(1, 8'h02);
    irq = 8'h42; wait_n(5);
    ack_pulse(); wait_n(1);
    wr_reg(0, 8'h40);
    irq = 0; wait_n(4);

    tag = "R6"; // spurious acknowledge
    ack_pulse(); wait_n(1);

    tag = "R10"; // deselected writes
    cs_n = 1; wr_n = 0; addr = 1; wdata = 8'hA5; tick(); idle();
    cs_n = 1; wr_n = 0; addr = 0; wdata = 8'hFF; tick(); idle();
    rd_reg(1); rd_reg(0);

    tag = "R8"; // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 7) == 0) irq = 8'($urandom);
      if (r < 10) ack_pulse();
      else if (r < 16) wr_reg(0, 8'h40);
      else if (r < 20) wr_reg(0, {6'b000000, 1'b0, 1'($urandom)});
      else if (r < 22) wr_reg(0, {6'b100000, 2'($urandom)});
      else if (r < 24) wr_reg(0, {2'b11, 6'($urandom)});
      else if (r < 26) wr_reg(1, 8'($urandom) & 8'($urandom));
      else if (r < 40) rd_reg(1'($urandom));
      else tick();
    end

    wait_n(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule